// File: doc/BRIEF.md
# Serial Port Hold Qualifier

This block sits between the pins of a serial memory slave and its protocol engine. It watches the serial clock, the active-low select and the active-low hold request, all three already brought into the block's clock domain. It turns each sampled serial-clock edge into a one-cycle enable pulse for the engine. While a hold is in effect it withholds those pulses, so the engine's shift registers and counters stay frozen. When the hold ends, the transfer carries on from the bit where it stopped.

The hold is tied to the serial-clock level. A hold request made while the clock is low takes effect at once. A request made while the clock is high waits for the next falling edge. That edge is still delivered, and the pause starts right after it. A release works the same way. With the clock low it takes effect at once. With the clock high it waits for the next falling edge, and that edge is swallowed so the engine never sees two falls in a row. The output-enable override drops in the same cycle that the hold request goes low, whatever the clock level. A configuration bit makes the block ignore the hold request entirely. Raising the select line cancels any hold.

Top module: `spi_hold_gate`

## Requirements
- R1: After reset neither edge pulse is raised until a serial-clock edge is seen. `so_oe` is 0 while `cs_n` is 1. `so_oe` is 1 when `cs_n` is 0 and `hold_n` is 1 with no hold in effect.
- R2: If `hold_n` is 0 while `sck` is 0, the hold is in effect from the next clock onward. Both edge pulses then stay 0 for every `sck` transition, and `so_oe` is 0.
- R3: If `hold_n` goes to 0 while `sck` is 1, no hold begins while `sck` stays high. The next falling `sck` edge is still delivered as `sck_fall_en`=1, and the hold is in effect from the following clock.
- R4: If `hold_n` returns to 1 while `sck` is 0, the hold ends in that cycle. `so_oe` returns to 1 at once, and the next `sck` edge is delivered.
- R5: If `hold_n` returns to 1 while `sck` is 1, the hold stays in effect and `so_oe` stays 0 until the next falling `sck` edge. That falling edge is not delivered (`sck_fall_en`=0), and `so_oe` returns to 1 in that same cycle.
- R6: Whenever `hold_n` is 0, `hold_dis` is 0 and `cs_n` is 0, `so_oe` is 0 in the same cycle, whatever the level of `sck`.
- R7: While `hold_dis` is 1, `hold_n` has no effect. Every `sck` edge is delivered, and `so_oe` equals the inverse of `cs_n`.
- R8: While `cs_n` is 1, `so_oe` is 0 and the hold state is cleared. After `cs_n` falls again with `hold_n` at 1, edges are delivered and `so_oe` is 1, even if `sck` is high.
- R9: Outside a hold, each `sck` transition between two consecutive clock samples raises exactly one pulse for one cycle. A 0-to-1 change raises `sck_rise_en` and a 1-to-0 change raises `sck_fall_en`.
- R10: Within one selection with `hold_dis` constant, the delivered edges strictly alternate between rise and fall, across any number of holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Synchronized serial clock level |
| cs_n | input | 1 | Synchronized active-low select |
| hold_n | input | 1 | Synchronized active-low hold request |
| hold_dis | input | 1 | 1 makes the block ignore the hold request |
| sck_rise_en | output | 1 | One-cycle pulse: rising serial-clock edge delivered to the engine |
| sck_fall_en | output | 1 | One-cycle pulse: falling serial-clock edge delivered to the engine |
| so_oe | output | 1 | 1 lets the engine drive the serial output, 0 forces high impedance |

## Verification
The bench goes first after the hold requests that arrive or leave while the serial clock is high. A design that froze at once on a high-clock request would lose the falling edge that R3 delivers. A design that delivered the releasing fall would hand the engine two falls in a row, and R10 would break. The bench also checks that the output override drops in the very cycle the request falls, even with the clock high, because a design that tied the override to the qualified hold state would drive stale data for half a serial period. It then checks that a hold left pending when the select rises does not survive into the next selection, where a stale hold would keep the output off. A sweep over every three-step sequence of the four inputs compares all three outputs, cycle by cycle, with a model built from the requirements.

// File: rtl/spi_hold_gate.sv
module spi_hold_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic hold_n,
  input  logic hold_dis,
  output logic sck_rise_en,
  output logic sck_fall_en,
  output logic so_oe
);

  logic sck_q;
  logic held_q;
  logic held_d;
  logic armed;

  assign armed  = !cs_n && !hold_dis;
  assign held_d = armed && (sck ? held_q : !hold_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      held_q <= 1'b0;
    end else begin
      sck_q  <= sck;
      held_q <= held_d;
    end
  end

  assign sck_rise_en = sck && !sck_q && !held_q;
  assign sck_fall_en = !sck && sck_q && !held_q;
  assign so_oe       = !cs_n && (hold_dis || (hold_n && !held_d));

  logic last_rise, seen, dis_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_rise <= 1'b0;
      seen      <= 1'b0;
      dis_q     <= 1'b0;
    end else begin
      dis_q <= hold_dis;
      if (cs_n || (hold_dis != dis_q)) begin
        seen      <= 1'b0;
        last_rise <= 1'b0;
      end else if (sck_rise_en || sck_fall_en) begin
        seen      <= 1'b1;
        last_rise <= sck_rise_en;
      end
    end
  end

  assert_held_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    held_q && !hold_n |-> !sck_rise_en && !sck_fall_en);

  assert_oe_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_n) && !hold_dis |-> !so_oe);

  assert_dis_ignores_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_dis && !cs_n |-> so_oe);

  assert_cs_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !held_q);

  assert_rise_alt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise_en && seen && !cs_n && (hold_dis == dis_q) |-> !last_rise);

  assert_fall_alt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sck_fall_en && seen && !cs_n && (hold_dis == dis_q) |-> last_rise);

endmodule

// File: tb/spi_hold_gate_tb.sv
module spi_hold_gate_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1, hold_dis = 1'b0;
  logic sck_rise_en, sck_fall_en, so_oe;

  int checks = 0;
  int errors = 0;

  logic m_ps = 1'b0, m_held = 1'b0;
  logic m_eff, m_rise, m_fall, m_oe;

  always #(CLK_PERIOD/2) clk = !clk;

  spi_hold_gate dut_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .hold_n(hold_n),
    .hold_dis(hold_dis), .sck_rise_en(sck_rise_en), .sck_fall_en(sck_fall_en),
    .so_oe(so_oe)
  );

  task automatic expect3(input string tag, input logic r, input logic f, input logic o);
    checks++;
    if (sck_rise_en !== r || sck_fall_en !== f || so_oe !== o) begin
      errors++;
      $display("FAIL %s: rise/fall/oe actual %b%b%b expected %b%b%b",
               tag, sck_rise_en, sck_fall_en, so_oe, r, f, o);
    end
  endtask

  task automatic drive(input logic s, input logic h, input logic c, input logic d);
    @(negedge clk);
    m_ps   = sck;
    m_held = m_eff;
    sck = s; hold_n = h; cs_n = c; hold_dis = d;
    #1;
    if (c || d)   m_eff = 1'b0;
    else if (!s)  m_eff = !h;
    else          m_eff = m_held;
    m_rise = s && !m_ps && !m_held;
    m_fall = !s && m_ps && !m_held;
    m_oe   = !c && (d || (h && !m_eff));
  endtask

  initial begin
    m_eff = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    expect3("R1 reset", 1'b0, 1'b0, 1'b0);

    drive(0,1,0,0); expect3("R1 select", 0,0,1);
    drive(1,1,0,0); expect3("R9 rise", 1,0,1);
    drive(0,1,0,0); expect3("R9 fall", 0,1,1);
    drive(0,0,0,0); expect3("R2 entry low", 0,0,0);
    drive(1,0,0,0); expect3("R2 rise blocked", 0,0,0);
    drive(0,0,0,0); expect3("R2 fall blocked", 0,0,0);
    drive(0,1,0,0); expect3("R4 release low", 0,0,1);
    drive(1,1,0,0); expect3("R4 next edge", 1,0,1);
    drive(1,0,0,0); expect3("R6 oe drops with sck high", 0,0,0);
    drive(0,0,0,0); expect3("R3 entry fall delivered", 0,1,0);
    drive(1,0,0,0); expect3("R3 held after fall", 0,0,0);
    drive(1,1,0,0); expect3("R5 release deferred", 0,0,0);
    drive(0,1,0,0); expect3("R5 release fall swallowed", 0,0,1);
    drive(1,1,0,0); expect3("R5 resume rise", 1,0,1);
    drive(0,1,0,0); expect3("R10 alternation fall", 0,1,1);
    drive(0,0,0,0); expect3("R2 entry again", 0,0,0);
    drive(0,0,1,0); expect3("R8 deselect", 0,0,0);
    drive(1,1,0,0); expect3("R8 no stale hold", 1,0,1);
    drive(0,0,0,1); expect3("R7 hold ignored fall", 0,1,1);
    drive(1,0,0,1); expect3("R7 hold ignored rise", 1,0,1);
    drive(1,0,1,1); expect3("R8 deselect oe off", 0,0,0);

    for (int seq = 0; seq < 4096; seq++) begin
      for (int k = 0; k < 3; k++) begin
        int v;
        v = (seq >> (4*k)) & 15;
        drive(v[0], v[1], v[2], v[3]);
        expect3("R9 sweep vs model", m_rise, m_fall, m_oe);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule